// File: doc/BRIEF.md
# Phase-Shifted Triangle Carrier Bank

This block generates the carrier set for phase-shifted PWM in a multilevel converter. One master triangle comes from a signed accumulator. It climbs by a step coefficient on every sample tick, flattens at full scale and then descends by the same step. Each output channel taps a delayed copy of that triangle from a shared circular sample store, using a per-channel delay that can be changed at run time. Each channel then compares its delayed carrier against a signed modulating reference and drives a complementary pair of gate signals.

The sample tick is an input enable. At a 40 MHz tick, one delay step is 25 ns and the deepest tap of 511 samples is 12.775 us. At a 2 MHz tick, one step is 0.5 us and the deepest tap is 255.5 us. A deeper tap is also available by raising the delay address width. The step coefficient is the wanted carrier frequency times four times the tick period, scaled so that full scale represents 1.0. For example, an 8-channel build serves a 9-level converter when the delays are spaced at one eighth of the carrier period.

Top module: `ptc_carrier_bank`

## Requirements
- R1: While reset is low and on the first cycle after it rises, master_o is -(2^(CW-1)-1) (-32767 for CW=16), every carrier_o lane is 0, and both gate vectors are all zero. The triangle starts on its rising slope.
- R2: On a tick the master rises by step_coef, or falls by it on the falling slope. A result at or beyond +(2^(CW-1)-1) is clamped to that value and the slope turns to falling. A result at or beyond -(2^(CW-1)-1) is clamped to that value and the slope turns to rising. The master never leaves that range.
- R3: In a cycle with tick_en low, master_o and every carrier lane keep their values.
- R4: Let T(k) be the value of master_o just before tick k. After tick k, carrier lane c (bits c*CW +: CW, signed) holds T(k-d), where d is lane c's delay (dly_i bits c*DLY_W +: DLY_W) sampled at that tick. A delay of 0 gives T(k).
- R5: Delays span 0 to 2^DLY_W-1 (511 by default) ticks. The deepest tap returns the sample written 511 ticks earlier.
- R6: A new delay value takes effect on the next tick, with no restart of the triangle.
- R7: After tick k with k < d (counting ticks from reset), lane c is not yet valid. Its carrier reads 0 and both of its gates are low one clock later.
- R8: On every clock, for each valid lane, gate_hi_o[c] is registered as 1 when the signed reference (ref_i bits c*CW +: CW) is strictly greater than that lane's carrier, and gate_lo_o[c] is registered as its complement. The gates reflect the carrier and valid state of the preceding clock.
- R9: With FIXED_DELAY set, lane delays come from the FIXED_TAPS parameter and dly_i has no effect.
- R10: gate_hi_o[c] and gate_lo_o[c] are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Sample tick enable; one triangle step per high cycle |
| step_coef | input | CW | Unsigned triangle step (fc x 4 x dT x full scale) |
| dly_i | input | NCH*DLY_W | Per-lane delay in ticks, lane c at c*DLY_W |
| ref_i | input | NCH*CW | Per-lane signed modulating reference |
| master_o | output | CW | Signed master triangle sample |
| carrier_o | output | NCH*CW | Per-lane signed delayed carrier |
| gate_hi_o | output | NCH | Upper gate command per lane |
| gate_lo_o | output | NCH | Complementary gate command per lane |

## Verification
The hardest situations to reach from the ports are the validity boundary at the deepest tap and the wrap of the circular store. Both need hundreds of ticks since reset before a 511-sample lane shows its first real sample. The bench therefore resets immediately before a long run with one lane at 511 and another at 0, so that the moment the lane turns valid falls inside the checked window. It then keeps running until the write position has wrapped. Run-time delay changes are applied in mid-triangle, and the reference model tracks every tick in its own history to predict each lane.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic {SLOPE_UP = 1'b0, SLOPE_DN = 1'b1} slope_e;
endpackage

// File: rtl/ptc_tri_accum.sv
module ptc_tri_accum
  import ptc_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CW-1:0]        step_coef,
  output logic signed [CW-1:0] tri_o
);
  localparam int EW = CW + 2;
  localparam logic signed [EW-1:0] TOP_E = EW'(2**(CW-1) - 1);
  localparam logic signed [EW-1:0] BOT_E = -TOP_E;

  function automatic logic signed [EW-1:0] widen(input logic signed [CW-1:0] v);
    return {{2{v[CW-1]}}, v};
  endfunction

  function automatic logic signed [EW-1:0] as_mag(input logic [CW-1:0] c);
    return {2'b00, c};
  endfunction

  slope_e               slope_q;
  logic signed [CW-1:0] tri_q;
  logic signed [EW-1:0] up_sum;
  logic signed [EW-1:0] dn_sum;

  always_comb begin
    up_sum = widen(tri_q) + as_mag(step_coef);
    dn_sum = widen(tri_q) - as_mag(step_coef);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tri_q   <= BOT_E[CW-1:0];
      slope_q <= SLOPE_UP;
    end else if (tick_en) begin
      if (slope_q == SLOPE_UP) begin
        if (up_sum >= TOP_E) begin
          tri_q   <= TOP_E[CW-1:0];
          slope_q <= SLOPE_DN;
        end else begin
          tri_q <= up_sum[CW-1:0];
        end
      end else begin
        if (dn_sum <= BOT_E) begin
          tri_q   <= BOT_E[CW-1:0];
          slope_q <= SLOPE_UP;
        end else begin
          tri_q <= dn_sum[CW-1:0];
        end
      end
    end
  end

  assign tri_o = tri_q;
endmodule

// File: rtl/ptc_delay_line.sv
module ptc_delay_line #(
  parameter int CW    = 16,
  parameter int DLY_W = 9,
  parameter int NCH   = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CW-1:0]        sample_i,
  input  logic [NCH*DLY_W-1:0] dly_i,
  output logic [NCH*CW-1:0]    tap_o,
  output logic [NCH-1:0]       valid_o
);
  localparam int DEPTH = 2**DLY_W;

  function automatic logic [DLY_W-1:0] rd_addr(input logic [DLY_W-1:0] wp,
                                               input logic [DLY_W-1:0] d);
    return wp - d;
  endfunction

  logic [CW-1:0]    store [DEPTH];
  logic [DLY_W-1:0] wr_ptr;
  logic [DLY_W-1:0] fill_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store[i] <= '0;
    end else if (tick_en) begin
      store[wr_ptr] <= sample_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      fill_q <= '0;
    end else if (tick_en) begin
      wr_ptr <= wr_ptr + 1'b1;
      if (fill_q != '1) fill_q <= fill_q + 1'b1;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_tap
    logic [DLY_W-1:0] d_c;
    logic [CW-1:0]    tap_q;
    logic             val_q;
    assign d_c = dly_i[c*DLY_W +: DLY_W];
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tap_q <= '0;
        val_q <= 1'b0;
      end else if (tick_en) begin
        tap_q <= (d_c == '0) ? sample_i : store[rd_addr(wr_ptr, d_c)];
        val_q <= (fill_q >= d_c);
      end
    end
    assign tap_o[c*CW +: CW] = tap_q;
    assign valid_o[c]        = val_q;
  end
endmodule

// File: rtl/ptc_pwm_cmp.sv
module ptc_pwm_cmp #(
  parameter int CW  = 16,
  parameter int NCH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*CW-1:0] car_i,
  input  logic [NCH*CW-1:0] ref_i,
  input  logic [NCH-1:0]    valid_i,
  output logic [NCH-1:0]    gate_hi_o,
  output logic [NCH-1:0]    gate_lo_o
);
  function automatic logic ref_above(input logic signed [CW-1:0] r,
                                     input logic signed [CW-1:0] car);
    return r > car;
  endfunction

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic hi_q, lo_q, above;
    assign above = ref_above(ref_i[c*CW +: CW], car_i[c*CW +: CW]);
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        hi_q <= 1'b0;
        lo_q <= 1'b0;
      end else begin
        hi_q <= valid_i[c] & above;
        lo_q <= valid_i[c] & ~above;
      end
    end
    assign gate_hi_o[c] = hi_q;
    assign gate_lo_o[c] = lo_q;
  end
endmodule

// File: rtl/ptc_carrier_bank.sv
module ptc_carrier_bank #(
  parameter int CW    = 16,
  parameter int DLY_W = 9,
  parameter int NCH   = 8,
  parameter bit FIXED_DELAY = 1'b0,
  parameter logic [NCH*DLY_W-1:0] FIXED_TAPS = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic [CW-1:0]        step_coef,
  input  logic [NCH*DLY_W-1:0] dly_i,
  input  logic [NCH*CW-1:0]    ref_i,
  output logic [CW-1:0]        master_o,
  output logic [NCH*CW-1:0]    carrier_o,
  output logic [NCH-1:0]       gate_hi_o,
  output logic [NCH-1:0]       gate_lo_o
);
  logic signed [CW-1:0] master_w;
  logic [NCH*DLY_W-1:0] eff_dly;
  logic [NCH-1:0]       chan_valid;

  if (FIXED_DELAY) begin : g_fixed
    assign eff_dly = FIXED_TAPS;
  end else begin : g_live
    assign eff_dly = dly_i;
  end

  ptc_tri_accum #(.CW(CW)) u_accum (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .step_coef(step_coef), .tri_o(master_w)
  );

  ptc_delay_line #(.CW(CW), .DLY_W(DLY_W), .NCH(NCH)) u_dline (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .sample_i(master_w), .dly_i(eff_dly),
    .tap_o(carrier_o), .valid_o(chan_valid)
  );

  ptc_pwm_cmp #(.CW(CW), .NCH(NCH)) u_cmp (
    .clk(clk), .rst_n(rst_n), .car_i(carrier_o), .ref_i(ref_i),
    .valid_i(chan_valid), .gate_hi_o(gate_hi_o), .gate_lo_o(gate_lo_o)
  );

  assign master_o = master_w;
endmodule

// File: rtl/ptc_carrier_bank_chk.sv
module ptc_carrier_bank_chk #(
  parameter int CW  = 16,
  parameter int NCH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [CW-1:0]     step_coef,
  input logic [CW-1:0]     master_o,
  input logic [NCH*CW-1:0] carrier_o,
  input logic [NCH-1:0]    gate_hi_o,
  input logic [NCH-1:0]    gate_lo_o,
  input logic [NCH-1:0]    chan_valid
);
  localparam int FS = 2**(CW-1) - 1;

  function automatic int abs_i(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int sval(input logic [CW-1:0] v);
    return int'($signed(v));
  endfunction

  p_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (sval(master_o) == -FS && carrier_o == '0 &&
                      gate_hi_o == '0 && gate_lo_o == '0));

  p_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sval(master_o) >= -FS && sval(master_o) <= FS));

  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_en |=> (abs_i(sval(master_o) - sval($past(master_o))) <= int'($past(step_coef))));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_en |=> ($stable(master_o) && $stable(carrier_o)));

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi_o ^ gate_lo_o) == $past(chan_valid)));

  p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((gate_hi_o & gate_lo_o) == '0));
endmodule

bind ptc_carrier_bank ptc_carrier_bank_chk #(.CW(CW), .NCH(NCH)) u_chk (.*);

// File: tb/test_ptc_carrier_bank.sv
`timescale 1ns/1ps
module test_ptc_carrier_bank;
  localparam int CW = 16, DW = 9, NCH = 8, FS = 32767, HN = 4096;

  function automatic logic [NCH*DW-1:0] mk_taps();
    logic [NCH*DW-1:0] v;
    for (int c = 0; c < NCH; c++) v[c*DW +: DW] = DW'(37*c + 5);
    return v;
  endfunction
  localparam logic [NCH*DW-1:0] FIX_TAPS = mk_taps();

  // coef, delay spacing, ref base, ref stride, ticks, clocks per tick
  localparam int ROWS = 6;
  localparam int VEC [ROWS][6] = '{
    '{1024,  16,      0,     0, 400, 1},
    '{4096,   3,   8000, -2000, 300, 1},
    '{300,   73, -20000,  5000, 700, 1},
    '{2048,  10,  12000,     0, 200, 3},
    '{65535,  1,      0,   100,  60, 1},
    '{0,      5,   -100,    40,  20, 2}
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, tick_en;
  logic [CW-1:0] coef;
  logic [NCH*DW-1:0] dly_v, dly_junk;
  logic [NCH*CW-1:0] ref_v;
  logic [CW-1:0] master, master_f;
  logic [NCH*CW-1:0] car, car_f;
  logic [NCH-1:0] ghi, glo, ghi_f, glo_f;

  ptc_carrier_bank #(.CW(CW), .DLY_W(DW), .NCH(NCH)) i_ptc_carrier_bank (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_coef(coef),
    .dly_i(dly_v), .ref_i(ref_v), .master_o(master), .carrier_o(car),
    .gate_hi_o(ghi), .gate_lo_o(glo));

  ptc_carrier_bank #(.CW(CW), .DLY_W(DW), .NCH(NCH), .FIXED_DELAY(1'b1),
                     .FIXED_TAPS(FIX_TAPS)) i_ptc_carrier_bank_fix (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .step_coef(coef),
    .dly_i(dly_junk), .ref_i(ref_v), .master_o(master_f), .carrier_o(car_f),
    .gate_hi_o(ghi_f), .gate_lo_o(glo_f));

  int n_cmp = 0, n_bad = 0;
  int m_tri, k, fix_warm;
  bit m_up, fix_on;
  int hist [HN];
  int car_e [NCH];
  bit val_e [NCH], ghi_e [NCH], glo_e [NCH];
  int d_b [NCH], r_b [NCH];
  string phase_tag = "";

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic apply_in();
    for (int c = 0; c < NCH; c++) begin
      dly_v[c*DW +: DW] = DW'(d_b[c]);
      ref_v[c*CW +: CW] = CW'(r_b[c]);
    end
    dly_junk = ~dly_v;
  endtask

  task automatic model_reset();
    m_tri = -FS; m_up = 1'b1; k = 0;
    for (int c = 0; c < NCH; c++) begin
      car_e[c] = 0; val_e[c] = 0; ghi_e[c] = 0; glo_e[c] = 0;
    end
  endtask

  task automatic model_step(input int cf);
    if (m_up) begin
      if (m_tri + cf >= FS) begin m_tri = FS; m_up = 1'b0; end
      else m_tri = m_tri + cf;
    end else begin
      if (m_tri - cf <= -FS) begin m_tri = -FS; m_up = 1'b1; end
      else m_tri = m_tri - cf;
    end
  endtask

  // one clock: drive at negedge, check at the following negedge
  task automatic cyc(input bit t);
    string tg;
    tick_en = t;
    apply_in();
    @(posedge clk);
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      ghi_e[c] = val_e[c] && (r_b[c] > car_e[c]);
      glo_e[c] = val_e[c] && !(r_b[c] > car_e[c]);
    end
    if (t) begin
      hist[k % HN] = m_tri;
      for (int c = 0; c < NCH; c++) begin
        val_e[c] = (k >= d_b[c]);
        car_e[c] = val_e[c] ? hist[(k - d_b[c]) % HN] : 0;
      end
      model_step(int'(coef));
      k++;
    end
    chk(t ? "R2 master" : "R3 master", int'($signed(master)), m_tri);
    for (int c = 0; c < NCH; c++) begin
      tg = !val_e[c] ? "R7" : ((phase_tag != "") ? phase_tag : "R4");
      chk({tg, " carrier"}, int'($signed(car[c*CW +: CW])), car_e[c]);
      chk("R8 gate_hi", int'(ghi[c]), int'(ghi_e[c]));
      chk("R8 gate_lo", int'(glo[c]), int'(glo_e[c]));
      chk("R10 exclusive", int'(ghi[c] & glo[c]), 0);
    end
    if (fix_on) begin
      fix_warm++;
      if (fix_warm > 2) begin
        chk("R9 fixed carrier", int'(car_f == car), 1);
        chk("R9 fixed gates", int'({ghi_f, glo_f} == {ghi, glo}), 1);
      end
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick_en = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset master", int'($signed(master)), -FS);
    chk("R1 reset carrier", int'(car == '0), 1);
    chk("R1 reset gates", int'({ghi, glo} == '0), 1);
    model_reset();
    rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick_en = 1'b0; coef = 16'd1024; fix_on = 1'b0; fix_warm = 0;
    for (int c = 0; c < NCH; c++) begin d_b[c] = 0; r_b[c] = 0; end
    apply_in();
    @(negedge clk);
    do_reset();

    // table of stimulus rows, expected values from the model
    for (int r = 0; r < ROWS; r++) begin
      coef = CW'(VEC[r][0]);
      for (int c = 0; c < NCH; c++) begin
        d_b[c] = c * VEC[r][1];
        r_b[c] = VEC[r][2] + c * VEC[r][3];
      end
      for (int i = 0; i < VEC[r][4]; i++) begin
        for (int j = 0; j < VEC[r][5] - 1; j++) cyc(1'b0);
        cyc(1'b1);
      end
    end

    // R5: deepest tap, validity boundary and store wrap after a fresh reset
    coef = 16'd700;
    d_b[0] = 511; d_b[1] = 0; d_b[2] = 510; d_b[3] = 1;
    for (int c = 4; c < NCH; c++) d_b[c] = 256;
    for (int c = 0; c < NCH; c++) r_b[c] = (c - 4) * 3000;
    apply_in();
    do_reset();
    phase_tag = "R5";
    for (int i = 0; i < 700; i++) cyc(1'b1);

    // R6: delays rewritten mid-run
    phase_tag = "R6";
    for (int p = 0; p < 6; p++) begin
      for (int c = 0; c < NCH; c++) d_b[c] = (d_b[c] + 97 + 13*c) % 512;
      for (int i = 0; i < 40; i++) cyc(1'b1);
      cyc(1'b0);
    end
    phase_tag = "";

    // R9: fixed-tap build ignores its delay input
    for (int c = 0; c < NCH; c++) d_b[c] = int'(FIX_TAPS[c*DW +: DW]);
    coef = 16'd1500;
    fix_on = 1'b1;
    for (int i = 0; i < 300; i++) cyc(1'b1);
    fix_on = 1'b0;

    // R1: reset in the middle of a run
    do_reset();
    chk("R1 after release", int'($signed(master)), -FS);
    for (int i = 0; i < 20; i++) cyc(1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule